// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank State Tracking

This block watches the command bus of a memory module that has two ranks of four-bank DDR SDRAM. On every rising clock edge it reads the chip selects, the RAS/CAS/WE triple, the bank address, the address bus, the data masks and the clock-enable pin. From these it produces a registered command record: a valid strobe, a command code, the target rank and bank, the row and column fields, an auto-precharge flag and a precharge bank mask. The same record carries the per-byte write-enable lanes.

For each bank of each rank, the block keeps an open flag and the row that was last activated. It checks incoming commands against this state. An activate to a bank that is already open is rejected, and so is a read or write to a closed bank. Either case raises a sequence error and the command is dropped. Asserting both chip selects at once raises a chip-select error.

When a read or write carries the auto-precharge bit, the bank closes by itself after half the configured burst length, counted in clock cycles, because two beats move per clock. Controllers and monitors use the outputs to follow bank state without decoding the pins themselves.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: Pins sampled at a rising edge show up on the outputs after that edge. The RAS/CAS/WE levels map to command codes as follows, with 0 meaning low:
  - 011 is activate, code 1.
  - 101 is read, code 2.
  - 100 is write, code 3.
  - 010 is precharge, code 4.
  - 001 is refresh, code 5.
  - 000 is mode-register set, code 6.
  - Every other combination is no operation. It gives cmd_valid low and code 0.
- R2: cs_n[0] low selects rank 0 and cs_n[1] low selects rank 1, which is reported on cmd_rank. With both high, the command is ignored. With both low while cke is high, err_cs pulses and no command is issued.
- R3: While cke is low, no command is accepted, so cmd_valid stays low and bank state does not change.
- R4: An activate opens the addressed bank. An activate to a bank that is already open is dropped and pulses err_seq.
- R5: A read or write reports the column from addr[9:0] and reports addr[10] as cmd_ap. A read or write to a closed bank is dropped and pulses err_seq.
- R6: A precharge with addr[10] high closes all four banks of the rank and reports pre_mask 4'hF. With addr[10] low, it closes only the bank named by ba and reports a one-hot pre_mask. For any other command, pre_mask is zero.
- R7: After a read or write with auto-precharge is accepted at edge T, the bank stays open until edge T+BL/2 and is closed after that edge. bl_sel selects BL: 0 gives 2, 1 gives 4, and 2 or 3 give 8. Without auto-precharge, the bank stays open.
- R8: On an issued write, wr_en is the bitwise inverse of dm. On every other cycle, wr_en is zero.
- R9: After reset, every bank is closed, no command is valid and both error flags are low.
- R10: open_rows holds the row of the last activate for each bank, at bit offset (rank*4+bank)*13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low blocks commands |
| cs_n | input | 2 | Active-low rank selects |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row / column / auto-precharge address |
| dm | input | 8 | Byte masks, high blocks the byte |
| bl_sel | input | 2 | Burst length select |
| cmd_valid | output | 1 | A command was issued |
| cmd_code | output | 3 | Issued command code |
| cmd_rank | output | 1 | Target rank |
| cmd_bank | output | 2 | Target bank |
| cmd_row | output | 13 | Address field as a row |
| cmd_col | output | 10 | Address field as a column |
| cmd_ap | output | 1 | Auto-precharge requested |
| pre_mask | output | 4 | Banks closed by a precharge |
| bank_open | output | 8 | Open flag per rank and bank |
| open_rows | output | 104 | Stored row per rank and bank |
| wr_en | output | 8 | Byte write lanes |
| err_cs | output | 1 | Both ranks selected |
| err_seq | output | 1 | Bank-state violation |

## Verification
The assertions run on every cycle and cover the following:
- A chip-select conflict always yields err_cs with no issued command.
- Low cke or two idle selects never issue a command.
- Write lanes stay zero outside writes.
- The precharge mask appears only with a precharge.
- An issued activate always leaves its bank marked open.

Only the bench scenarios can show the rest:
- The actual timing of the auto-precharge countdown for each burst length.
- The separation between the two ranks.
- The recorded row values.
- The rejection of out-of-order activates, reads and writes.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    // Map the three strobe levels onto a command
    function automatic cmd_e strobe_to_cmd(input logic ras_n, input logic cas_n, input logic we_n);
        cmd_e c;
        case ({ras_n, cas_n, we_n})
            3'b011:  c = CMD_ACT;
            3'b101:  c = CMD_RD;
            3'b100:  c = CMD_WR;
            3'b010:  c = CMD_PRE;
            3'b001:  c = CMD_REF;
            3'b000:  c = CMD_MRS;
            default: c = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ddr_cmd_pin_decode.sv
module ddr_cmd_pin_decode
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 cke,
    input  logic [NUM_RANKS-1:0] cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    output cmd_e                 cmd,
    output logic [RANK_W-1:0]    rank,
    output logic                 one_sel,
    output logic                 multi_sel
);
    logic [$clog2(NUM_RANKS+1)-1:0] sel_cnt;

    always_comb begin
        cmd     = strobe_to_cmd(ras_n, cas_n, we_n);
        rank    = '0;
        sel_cnt = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (!cs_n[r]) begin
                rank    = RANK_W'(r);
                sel_cnt = sel_cnt + 1'b1;
            end
        end
        one_sel   = cke && (sel_cnt == 1);
        multi_sel = cke && (sel_cnt > 1);
    end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int CNT_W     = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       act_en,
    input  logic                       pre_en,
    input  logic [NUM_BANKS-1:0]       pre_mask,
    input  logic                       ap_en,
    input  logic [BANK_W-1:0]          bank,
    input  logic [ROW_W-1:0]           row,
    input  logic [CNT_W-1:0]           ap_cycles,
    output logic [NUM_BANKS-1:0]       open,
    output logic [NUM_BANKS*ROW_W-1:0] rows
);
    typedef struct packed {
        logic [NUM_BANKS-1:0]             open;
        logic [NUM_BANKS-1:0][ROW_W-1:0]  row;
        logic [NUM_BANKS-1:0][CNT_W-1:0]  cnt;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // pending auto-precharge countdowns keep running in every cycle
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st_q.cnt[b] != '0) begin
                if (st_q.cnt[b] == CNT_W'(1)) begin
                    st_d.open[b] = 1'b0;
                    st_d.cnt[b]  = '0;
                end else begin
                    st_d.cnt[b] = st_q.cnt[b] - 1'b1;
                end
            end
        end
        if (pre_en) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (pre_mask[b]) begin
                    st_d.open[b] = 1'b0;
                    st_d.cnt[b]  = '0;
                end
            end
        end
        if (act_en) begin
            st_d.open[bank] = 1'b1;
            st_d.row[bank]  = row;
            st_d.cnt[bank]  = '0;
        end
        if (ap_en) begin
            st_d.cnt[bank] = ap_cycles;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open = st_q.open;
    assign rows = st_q.row;
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 13,
    parameter int COL_W     = 10,
    parameter int AP_BIT    = 10,
    parameter int DM_W      = 8,
    parameter int MAX_BL    = 8,
    localparam int NUM_BANKS = 1 << BA_W,
    localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int CNT_W     = $clog2(MAX_BL / 2 + 1),
    localparam int NSLOT     = NUM_RANKS * NUM_BANKS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cke,
    input  logic [NUM_RANKS-1:0]      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DM_W-1:0]           dm,
    input  logic [1:0]                bl_sel,
    output logic                      cmd_valid,
    output logic [2:0]                cmd_code,
    output logic [RANK_W-1:0]         cmd_rank,
    output logic [BA_W-1:0]           cmd_bank,
    output logic [ADDR_W-1:0]         cmd_row,
    output logic [COL_W-1:0]          cmd_col,
    output logic                      cmd_ap,
    output logic [NUM_BANKS-1:0]      pre_mask,
    output logic [NSLOT-1:0]          bank_open,
    output logic [NSLOT*ADDR_W-1:0]   open_rows,
    output logic [DM_W-1:0]           wr_en,
    output logic                      err_cs,
    output logic                      err_seq
);
    typedef struct packed {
        logic                 valid;
        logic [2:0]           code;
        logic [RANK_W-1:0]    rank;
        logic [BA_W-1:0]      bank;
        logic [ADDR_W-1:0]    row;
        logic [COL_W-1:0]     col;
        logic                 ap;
        logic [NUM_BANKS-1:0] pmask;
        logic [DM_W-1:0]      wr;
        logic                 ecs;
        logic                 eseq;
    } out_t;

    out_t out_d, out_q;

    cmd_e              cmd;
    logic [RANK_W-1:0] rank;
    logic              one_sel, multi_sel;
    logic              accept, seq_bad, issue, tgt_open, is_rw;
    logic [NUM_BANKS-1:0] pmask_c;
    logic [CNT_W-1:0]  ap_cycles;

    ddr_cmd_pin_decode #(.NUM_RANKS(NUM_RANKS)) u_pins (
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cmd      (cmd),
        .rank     (rank),
        .one_sel  (one_sel),
        .multi_sel(multi_sel)
    );

    always_comb begin
        case (bl_sel)
            2'd0:    ap_cycles = CNT_W'(1);
            2'd1:    ap_cycles = CNT_W'(2);
            default: ap_cycles = CNT_W'(MAX_BL / 2);
        endcase
        tgt_open = bank_open[{rank, ba}];
        is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
        accept   = one_sel && (cmd != CMD_NOP);
        seq_bad  = accept && (((cmd == CMD_ACT) && tgt_open) || (is_rw && !tgt_open));
        issue    = accept && !seq_bad;
        pmask_c  = addr[AP_BIT] ? '1 : (NUM_BANKS'(1) << ba);

        out_d       = '0;
        out_d.ecs   = multi_sel;
        out_d.eseq  = seq_bad;
        if (issue) begin
            out_d.valid = 1'b1;
            out_d.code  = cmd;
            out_d.rank  = rank;
            out_d.bank  = ba;
            out_d.row   = addr;
            out_d.col   = addr[COL_W-1:0];
            out_d.ap    = is_rw && addr[AP_BIT];
            out_d.pmask = (cmd == CMD_PRE) ? pmask_c : '0;
            out_d.wr    = (cmd == CMD_WR) ? ~dm : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // one tracker per rank
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic hit;
        assign hit = issue && (rank == RANK_W'(r));

        ddr_bank_tracker #(
            .NUM_BANKS(NUM_BANKS),
            .ROW_W    (ADDR_W),
            .CNT_W    (CNT_W)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_en   (hit && (cmd == CMD_ACT)),
            .pre_en   (hit && (cmd == CMD_PRE)),
            .pre_mask (pmask_c),
            .ap_en    (hit && is_rw && addr[AP_BIT]),
            .bank     (ba),
            .row      (addr),
            .ap_cycles(ap_cycles),
            .open     (bank_open[r*NUM_BANKS +: NUM_BANKS]),
            .rows     (open_rows[r*NUM_BANKS*ADDR_W +: NUM_BANKS*ADDR_W])
        );
    end

    assign cmd_valid = out_q.valid;
    assign cmd_code  = out_q.code;
    assign cmd_rank  = out_q.rank;
    assign cmd_bank  = out_q.bank;
    assign cmd_row   = out_q.row;
    assign cmd_col   = out_q.col;
    assign cmd_ap    = out_q.ap;
    assign pre_mask  = out_q.pmask;
    assign wr_en     = out_q.wr;
    assign err_cs    = out_q.ecs;
    assign err_seq   = out_q.eseq;
endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
    parameter int NUM_RANKS = 2,
    parameter int BA_W      = 2,
    parameter int DM_W      = 8,
    localparam int NUM_BANKS = 1 << BA_W,
    localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cke,
    input logic [NUM_RANKS-1:0]           cs_n,
    input logic                           cmd_valid,
    input logic [2:0]                     cmd_code,
    input logic [RANK_W-1:0]              cmd_rank,
    input logic [BA_W-1:0]                cmd_bank,
    input logic [NUM_BANKS-1:0]           pre_mask,
    input logic [NUM_RANKS*NUM_BANKS-1:0] bank_open,
    input logic [DM_W-1:0]                wr_en,
    input logic                           err_cs
);
    // R2
    dual_select_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && ($countones(~cs_n) > 1)) |=> (err_cs && !cmd_valid));

    // R2
    idle_select_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && (&cs_n)) |=> !cmd_valid);

    // R3
    clock_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> !cmd_valid);

    // R8
    lanes_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && (cmd_code == 3'd3)) |-> (wr_en == '0));

    // R6
    mask_only_on_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 3'd4)) ? (pre_mask != '0) : (pre_mask == '0));

    // R4
    activate_marks_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 3'd1)) |-> bank_open[{cmd_rank, cmd_bank}]);
endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk u_chk (.*);

// File: tb/ddr_cmd_decoder_tb.sv
`timescale 1ns/1ps
module ddr_cmd_decoder_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cke = 1'b1;
    logic [1:0]   cs_n = 2'b11;
    logic         ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]   ba = '0;
    logic [12:0]  addr = '0;
    logic [7:0]   dm = '0;
    logic [1:0]   bl_sel = 2'd2;
    logic         cmd_valid, cmd_ap, err_cs, err_seq;
    logic [2:0]   cmd_code;
    logic [0:0]   cmd_rank;
    logic [1:0]   cmd_bank;
    logic [12:0]  cmd_row;
    logic [9:0]   cmd_col;
    logic [3:0]   pre_mask;
    logic [7:0]   bank_open;
    logic [103:0] open_rows;
    logic [7:0]   wr_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .dm(dm), .bl_sel(bl_sel), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap), .pre_mask(pre_mask),
        .bank_open(bank_open), .open_rows(open_rows), .wr_en(wr_en),
        .err_cs(err_cs), .err_seq(err_seq)
    );

    // strobe levels {ras_n,cas_n,we_n}
    localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                           P_PRE = 3'b010, P_REF = 3'b001, P_NOP = 3'b111;

    // {cs_n, strobes, ba, addr, dm, exp_valid, exp_code, exp_wr, exp_ecs, exp_eseq, exp_open_rank0}
    localparam int NV = 14;
    localparam logic [45:0] VEC [NV] = '{
        {2'b10, P_ACT, 2'd1, 13'h0ABC, 8'h00, 1'b1, 3'd1, 8'h00, 1'b0, 1'b0, 4'b0010},
        {2'b10, P_ACT, 2'd1, 13'h0123, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 4'b0010},
        {2'b10, P_WR,  2'd1, 13'h0055, 8'hF0, 1'b1, 3'd3, 8'h0F, 1'b0, 1'b0, 4'b0010},
        {2'b10, P_RD,  2'd1, 13'h0055, 8'hFF, 1'b1, 3'd2, 8'h00, 1'b0, 1'b0, 4'b0010},
        {2'b10, P_RD,  2'd2, 13'h0000, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 4'b0010},
        {2'b00, P_ACT, 2'd2, 13'h0001, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 4'b0010},
        {2'b11, P_ACT, 2'd2, 13'h0001, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0010},
        {2'b10, P_ACT, 2'd3, 13'h0777, 8'h00, 1'b1, 3'd1, 8'h00, 1'b0, 1'b0, 4'b1010},
        {2'b10, P_PRE, 2'd1, 13'h0000, 8'h00, 1'b1, 3'd4, 8'h00, 1'b0, 1'b0, 4'b1000},
        {2'b10, P_ACT, 2'd0, 13'h0002, 8'h00, 1'b1, 3'd1, 8'h00, 1'b0, 1'b0, 4'b1001},
        {2'b10, P_PRE, 2'd1, 13'h0400, 8'h00, 1'b1, 3'd4, 8'h00, 1'b0, 1'b0, 4'b0000},
        {2'b10, P_REF, 2'd0, 13'h0000, 8'h00, 1'b1, 3'd5, 8'h00, 1'b0, 1'b0, 4'b0000},
        {2'b10, P_NOP, 2'd0, 13'h0000, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0000},
        {2'b10, P_WR,  2'd0, 13'h0000, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 4'b0000}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the sampling edge
    task automatic issue(input logic [1:0] c, input logic [2:0] p, input logic [1:0] b,
                         input logic [12:0] a, input logic [7:0] m);
        cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr = a; dm = m;
        @(posedge clk);
        @(negedge clk);
        cs_n = 2'b11; {ras_n, cas_n, we_n} = P_NOP; ba = '0; addr = '0; dm = '0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cmd_valid == 1'b0, "R9 valid", cmd_valid, 0);
        chk(bank_open == 8'h00, "R9 open", bank_open, 0);
        chk({err_cs, err_seq} == 2'b00, "R9 errors", {err_cs, err_seq}, 0);
        rst_n = 1'b1;
        idle();

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][45:44], VEC[i][43:41], VEC[i][40:39], VEC[i][38:26], VEC[i][25:18]);
            chk(cmd_valid == VEC[i][17], $sformatf("R1 valid v%0d", i), cmd_valid, VEC[i][17]);
            chk(cmd_code == VEC[i][16:14], $sformatf("R1 code v%0d", i), cmd_code, VEC[i][16:14]);
            chk(wr_en == VEC[i][13:6], $sformatf("R8 lanes v%0d", i), wr_en, VEC[i][13:6]);
            chk(err_cs == VEC[i][5], $sformatf("R2 err_cs v%0d", i), err_cs, VEC[i][5]);
            chk(err_seq == VEC[i][4], $sformatf("R4 err_seq v%0d", i), err_seq, VEC[i][4]);
            chk(bank_open[3:0] == VEC[i][3:0], $sformatf("R6 open v%0d", i), bank_open[3:0], VEC[i][3:0]);
        end

        // R2 / R10: rank 1 is independent
        issue(2'b01, P_ACT, 2'd2, 13'h1234, 8'h00);
        chk(cmd_valid && cmd_rank == 1'b1, "R2 rank1", {cmd_valid, cmd_rank}, 2'b11);
        chk(bank_open == 8'b0100_0000, "R2 rank1 open", bank_open, 8'b0100_0000);
        chk(open_rows[6*13 +: 13] == 13'h1234, "R10 row r1b2", open_rows[6*13 +: 13], 13'h1234);
        chk(open_rows[1*13 +: 13] == 13'h0ABC, "R10 row r0b1", open_rows[1*13 +: 13], 13'h0ABC);

        // R6 single-bank precharge mask
        issue(2'b01, P_PRE, 2'd2, 13'h0000, 8'h00);
        chk(pre_mask == 4'b0100, "R6 pre_mask", pre_mask, 4'b0100);
        chk(bank_open == 8'h00, "R6 closed", bank_open, 0);

        // R3 clock enable low
        cke = 1'b0;
        issue(2'b10, P_ACT, 2'd2, 13'h0009, 8'h00);
        chk(cmd_valid == 1'b0, "R3 valid", cmd_valid, 0);
        chk(bank_open == 8'h00, "R3 open", bank_open, 0);
        cke = 1'b1;

        // R5 / R7: write without auto-precharge keeps the bank open
        issue(2'b10, P_ACT, 2'd1, 13'h0042, 8'h00);
        issue(2'b10, P_WR, 2'd1, 13'h0012, 8'h00);
        chk(cmd_ap == 1'b0 && cmd_col == 10'h012, "R5 no ap", {cmd_ap, cmd_col}, 11'h012);
        repeat (5) idle();
        chk(bank_open[1] == 1'b1, "R7 no ap stays open", bank_open[1], 1);
        issue(2'b10, P_PRE, 2'd1, 13'h0000, 8'h00);

        // R7 auto-precharge for each burst length
        for (int s = 0; s < 3; s++) begin
            int cyc;
            cyc = (s == 0) ? 1 : (s == 1) ? 2 : 4;
            bl_sel = 2'(s);
            issue(2'b10, P_ACT, 2'd0, 13'h0005, 8'h00);
            issue(2'b10, P_RD, 2'd0, 13'h0410, 8'h00);
            chk(cmd_ap == 1'b1 && cmd_col == 10'h010, "R5 ap col", {cmd_ap, cmd_col}, 11'h410);
            chk(bank_open[0] == 1'b1, "R7 open at T", bank_open[0], 1);
            for (int j = 1; j <= cyc; j++) begin
                idle();
                chk(bank_open[0] == (j < cyc), $sformatf("R7 bl_sel%0d j%0d", s, j),
                    bank_open[0], (j < cyc));
            end
        end

        report();
    end
endmodule